// File: doc/BRIEF.md
# Triple-Slot Majority Voter with Spare Substitution

This block sits behind a set of identical computing modules that all run the same work in lockstep. Three of them are active at any time, each assigned to a voting slot; the rest wait as spares. Each cycle, a crossbar picks one module for each slot. A bitwise two-of-three majority of those three words is the block's result. Because the vote and the crossbar are combinational, the output always reflects the current inputs.

Each slot's word is compared against the voted result. A slot that keeps disagreeing for a programmable number of back-to-back cycles has its module retired. The retired module is marked failed for good, and the lowest-numbered spare that is neither failed nor in use takes its place. A shorter burst of disagreement is simply outvoted. Once no usable spare remains, the slot mapping freezes: single faults are still outvoted, and a disagreement on two slots at once is reported as beyond repair.

Top module: `tmr_spare_top`

## Requirements
- R1: `voted` equals, bit by bit, the majority of the three words selected by the current slot mapping. A single wrong bit in each of two different modules at different bit positions is still voted out.
- R2: `err` is 1 in every cycle in which at least one selected word differs from `voted`, and 0 when all three agree. A module that is the only one in disagreement never changes `voted`.
- R3: A slot whose disagreement lasts fewer than PERSIST consecutive rising edges is not remapped. Any cycle of agreement restarts that slot's count from zero.
- R4: When a slot has disagreed at PERSIST consecutive rising edges and a spare is available, its mapping changes at that PERSIST-th edge.
- R5: Slot s holds module s after reset. Spares are modules 3 to 3+NSPARE-1 and are taken lowest index first. Field s of `slot_map` sits at bits [s*IDXW +: IDXW], with IDXW = $clog2(3+NSPARE).
- R6: A retired module is marked failed permanently and is never mapped into a slot again. A spare that later faults while active is itself replaced by the next free spare.
- R7: `spare_empty` is 1 exactly when every spare is either in use or failed. While it is 1, the mapping no longer changes, and disagreement is still outvoted and still flagged on `err`.
- R8: `uncorrectable` is 1 when `spare_empty` is 1 and two or more slots disagree with the vote in the same cycle. It is 0 whenever a spare remains.
- R9: If several slots reach the threshold in the same cycle, only the lowest-numbered slot is remapped at that edge. Each other slot keeps its saturated count and is remapped at the following edge if it is still disagreeing.
- R10: After reset, the mapping is identity, `spare_empty` and `uncorrectable` are 0, and with agreeing modules `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_data | input | (3+NSPARE)*W | Module output words; module i at bits [i*W +: W] |
| voted | output | W | Bitwise majority of the three selected words |
| err | output | 1 | At least one selected word disagrees with the vote |
| spare_empty | output | 1 | No usable spare remains |
| uncorrectable | output | 1 | Spares exhausted and two or more slots disagree |
| slot_map | output | 3*IDXW | Module index feeding each slot |

## Verification
The bench targets the edge of the persistence window. It applies a fault for exactly PERSIST-1 edges, then for exactly PERSIST edges. An off-by-one counter would therefore either swap on a transient or swap one cycle late.

It also targets two slots reaching the threshold together. A design without one-swap-per-cycle arbitration would hand the same spare to both slots, or lose the second replacement.

A spare that faults after being brought in must be replaced by the next spare and never returned to. Reusing it would show up as a repeated index in the mapping or as `spare_empty` staying low.

Finally, with spares exhausted, two slots are made to disagree on different bits. A design that ignored spare state would either raise `uncorrectable` too early or keep remapping.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NACT = 3;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction
endpackage

// File: rtl/tmr_switch.sv
module tmr_switch
    import tmr_pkg::*;
#(
    parameter int W    = 8,
    parameter int NMOD = 5,
    parameter int IDXW = 3
) (
    input  logic [NMOD-1:0][W-1:0] mods_i,
    input  logic [NACT-1:0][IDXW-1:0] map_i,
    output logic [NACT-1:0][W-1:0] sel_o
);
    for (genvar s = 0; s < NACT; s++) begin : g_slot
        always_comb begin
            sel_o[s] = '0;
            for (int m = 0; m < NMOD; m++) begin
                if (map_i[s] == IDXW'(m)) sel_o[s] = mods_i[m];
            end
        end
    end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NACT-1:0][W-1:0] din_i,
    output logic [W-1:0]           vote_o,
    output logic [NACT-1:0]        dis_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign vote_o[b] = maj3(din_i[0][b], din_i[1][b], din_i[2][b]);
    end

    for (genvar s = 0; s < NACT; s++) begin : g_cmp
        assign dis_o[s] = (din_i[s] != vote_o);
    end
endmodule

// File: rtl/tmr_reconfig.sv
module tmr_reconfig
    import tmr_pkg::*;
#(
    parameter  int NSPARE  = 2,
    parameter  int PERSIST = 3,
    localparam int NMOD    = NACT + NSPARE,
    localparam int IDXW    = $clog2(NMOD),
    localparam int CW      = $clog2(PERSIST + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NACT-1:0]           dis_i,
    output logic [NACT-1:0][IDXW-1:0] map_o,
    output logic                      spare_empty_o
);
    typedef struct packed {
        logic [NACT-1:0][IDXW-1:0] map;
        logic [NMOD-1:0]           failed;
        logic [NACT-1:0][CW-1:0]   cnt;
    } rc_state_t;

    rc_state_t st_d, st_q;
    logic [NMOD-1:0] inuse;
    logic [IDXW-1:0] cand;
    logic            have;

    always_comb begin
        logic fire;
        logic granted;
        inuse = '0;
        for (int s = 0; s < NACT; s++) begin
            for (int m = 0; m < NMOD; m++) begin
                if (st_q.map[s] == IDXW'(m)) inuse[m] = 1'b1;
            end
        end
        cand = '0;
        have = 1'b0;
        for (int m = NMOD - 1; m >= NACT; m--) begin
            if (!st_q.failed[m] && !inuse[m]) begin
                cand = IDXW'(m);
                have = 1'b1;
            end
        end

        st_d    = st_q;
        granted = 1'b0;
        fire    = 1'b0;
        for (int s = 0; s < NACT; s++) begin
            fire = dis_i[s] && (st_q.cnt[s] == CW'(PERSIST - 1));
            if (!dis_i[s]) begin
                st_d.cnt[s] = '0;
            end else if (fire && have && !granted) begin
                for (int m = 0; m < NMOD; m++) begin
                    if (st_q.map[s] == IDXW'(m)) st_d.failed[m] = 1'b1;
                end
                st_d.map[s] = cand;
                st_d.cnt[s] = '0;
                granted     = 1'b1;
            end else if (st_q.cnt[s] < CW'(PERSIST - 1)) begin
                st_d.cnt[s] = st_q.cnt[s] + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NACT; s++) begin
                st_q.map[s] <= IDXW'(s);
                st_q.cnt[s] <= '0;
            end
            st_q.failed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_o         = st_q.map;
    assign spare_empty_o = !have;

    for (genvar s = 0; s < NACT; s++) begin : g_slot_chk
        p_swap_needs_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(st_q.map[s]) |-> $past(dis_i[s]));
    end

    for (genvar m = 0; m < NMOD; m++) begin : g_mod_chk
        p_failed_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.failed[m] |=> st_q.failed[m]);
        p_failed_not_mapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.failed[m] |-> (st_q.map[0] != IDXW'(m) && st_q.map[1] != IDXW'(m)
                                && st_q.map[2] != IDXW'(m)));
    end

    p_empty_freezes_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spare_empty_o |=> $stable(st_q.map));

    p_distinct_slots_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.map[0] != st_q.map[1]) && (st_q.map[0] != st_q.map[2])
        && (st_q.map[1] != st_q.map[2]));
endmodule

// File: rtl/tmr_spare_top.sv
module tmr_spare_top
    import tmr_pkg::*;
#(
    parameter  int W       = 8,
    parameter  int NSPARE  = 2,
    parameter  int PERSIST = 3,
    localparam int NMOD    = NACT + NSPARE,
    localparam int IDXW    = $clog2(NMOD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NMOD*W-1:0]    mod_data,
    output logic [W-1:0]         voted,
    output logic                 err,
    output logic                 spare_empty,
    output logic                 uncorrectable,
    output logic [NACT*IDXW-1:0] slot_map
);
    logic [NMOD-1:0][W-1:0]    mods;
    logic [NACT-1:0][IDXW-1:0] map;
    logic [NACT-1:0][W-1:0]    sel;
    logic [NACT-1:0]           dis;

    assign mods = mod_data;

    tmr_switch #(.W(W), .NMOD(NMOD), .IDXW(IDXW)) i_switch (
        .mods_i (mods),
        .map_i  (map),
        .sel_o  (sel)
    );

    tmr_voter #(.W(W)) i_voter (
        .din_i  (sel),
        .vote_o (voted),
        .dis_o  (dis)
    );

    tmr_reconfig #(.NSPARE(NSPARE), .PERSIST(PERSIST)) i_reconfig (
        .clk           (clk),
        .rst_n         (rst_n),
        .dis_i         (dis),
        .map_o         (map),
        .spare_empty_o (spare_empty)
    );

    assign err           = |dis;
    assign uncorrectable = spare_empty && ((dis[0] & dis[1]) | (dis[0] & dis[2]) | (dis[1] & dis[2]));
    assign slot_map      = map;

    p_pair_agree_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[0] == sel[1]) |-> (voted == sel[0] && !dis[0] && !dis[1]));

    p_unanimous_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[0] == sel[1] && sel[1] == sel[2]) |-> !err);
endmodule

// File: tb/test_tmr_spare_top.sv
`timescale 1ns/1ps
module test_tmr_spare_top;
    localparam int W = 8;
    localparam int NSPARE = 2;
    localparam int PERSIST = 3;
    localparam int NMOD = 3 + NSPARE;
    localparam int IDXW = $clog2(NMOD);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NMOD*W-1:0] mod_data;
    logic [W-1:0] voted;
    logic err, spare_empty, uncorrectable;
    logic [3*IDXW-1:0] slot_map;

    logic [W-1:0] gold = '0;
    logic [NMOD-1:0][W-1:0] fmask = '0;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NMOD; i++) mod_data[i*W +: W] = gold ^ fmask[i];
    end

    tmr_spare_top #(.W(W), .NSPARE(NSPARE), .PERSIST(PERSIST)) i_tmr_spare_top (
        .clk(clk), .rst_n(rst_n), .mod_data(mod_data), .voted(voted), .err(err),
        .spare_empty(spare_empty), .uncorrectable(uncorrectable), .slot_map(slot_map)
    );

    function automatic int slot(input int s);
        return int'(slot_map[s*IDXW +: IDXW]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply(input logic [W-1:0] g);
        gold = g;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fmask = '0;
        gold = 8'h5a;
        cyc(3);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 slot0", slot(0), 0);
        chk("R10 slot1", slot(1), 1);
        chk("R10 slot2", slot(2), 2);
        chk("R10 spare_empty", spare_empty, 0);
        chk("R10 uncorrectable", uncorrectable, 0);
        chk("R10 err", err, 0);
    endtask

    task automatic t_clean_vote();
        logic [W-1:0] pats [4] = '{8'h00, 8'hff, 8'ha5, 8'h3c};
        foreach (pats[k]) begin
            apply(pats[k]);
            chk("R1 vote clean", voted, pats[k]);
            chk("R2 err clean", err, 0);
        end
        // R1 bitwise: different bits wrong in two modules
        fmask[0] = 8'h01;
        fmask[1] = 8'h80;
        apply(8'h69);
        chk("R1 bitwise masking", voted, 8'h69);
        chk("R2 err on split", err, 1);
        fmask = '0;
        #1;
    endtask

    task automatic t_transient();
        fmask[1] = 8'h10;
        apply(8'hc3);
        chk("R2 single fault masked", voted, 8'hc3);
        chk("R2 err raised", err, 1);
        cyc(PERSIST - 1);
        chk("R3 no swap below window", slot(1), 1);
        fmask = '0;
        cyc(1);
        fmask[1] = 8'h10;
        #1;
        cyc(PERSIST - 1);
        chk("R3 count restarts", slot(1), 1);
        fmask = '0;
        cyc(1);
    endtask

    task automatic t_replace_chain();
        do_reset();
        fmask[1] = 8'h04;
        apply(8'h96);
        cyc(PERSIST - 1);
        chk("R4 not yet swapped", slot(1), 1);
        cyc(1);
        chk("R4 swapped at window", slot(1), 3);
        chk("R5 lowest spare first", slot(1), 3);
        chk("R4 err clears after swap", err, 0);
        chk("R7 spare left", spare_empty, 0);
        fmask[3] = 8'h40;
        #1;
        chk("R2 spare fault masked", voted, 8'h96);
        cyc(PERSIST);
        chk("R6 faulty spare replaced", slot(1), 4);
        chk("R7 exhausted", spare_empty, 1);
        chk("R6 failed never reused slot0", slot(0), 0);
        fmask[1] = 8'h00;
        fmask[3] = 8'h00;
        fmask[0] = 8'h02;
        #1;
        cyc(PERSIST + 2);
        chk("R7 map frozen", slot(0), 0);
        chk("R7 still masked", voted, 8'h96);
        chk("R7 err still flagged", err, 1);
        chk("R8 one disagree not unc", uncorrectable, 0);
        fmask[2] = 8'h20;
        #1;
        chk("R8 two disagree unc", uncorrectable, 1);
        chk("R8 still voted", voted, 8'h96);
        fmask = '0;
        #1;
        chk("R8 clears", uncorrectable, 0);
    endtask

    task automatic t_two_with_spares();
        do_reset();
        fmask[0] = 8'h01;
        fmask[2] = 8'h08;
        apply(8'h11);
        chk("R8 spares remain no unc", uncorrectable, 0);
        chk("R1 two-bit split", voted, 8'h11);
        cyc(PERSIST);
        chk("R9 lowest slot first", slot(0), 3);
        chk("R9 other waits", slot(2), 2);
        cyc(1);
        chk("R9 second next edge", slot(2), 4);
        chk("R5 slot1 untouched", slot(1), 1);
        chk("R7 exhausted after two", spare_empty, 1);
        fmask = '0;
        cyc(1);
    endtask

    initial begin
        t_reset_state();
        t_clean_vote();
        t_transient();
        t_replace_chain();
        t_two_with_spares();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule